// File: doc/BRIEF.md
# DDR SDRAM Refresh Scheduler

This block decides when a DDR SDRAM must be refreshed and asks a command arbiter for the command slots it needs. A free-running interval counter adds one unit of refresh debt each average refresh period. While debt is owed and the scheduler is idle, it raises a request to the arbiter. If any bank is open at that moment, it first requests a precharge-all and waits out the precharge time. It then requests the refresh itself. After each refresh it holds off every other command for the refresh cycle time, and clock enable stays high throughout.

Debt is capped at a ceiling of eight postponed refreshes. At the ceiling the request is flagged urgent so that the arbiter serves it ahead of other traffic. The scheduler also takes the memory into and out of self refresh. Entry goes through the same precharge and grant path. Exit is a command the scheduler puts out by itself, and it is followed by two independent hold-off windows: a short one for any command that is not a read, and a long one for reads. All minimum times are cycle-count parameters, each rounded up to whole clock periods.

Top module: `rfsh_sched`

## Requirements
- R1: Debt grows by one every `REFI_CYC` clock edges, counted from reset. The first request appears at the port after edge `REFI_CYC`+1.
- R2: If `banks_open_i` is high when a request is formed, the first granted command is a precharge-all. The refresh request then returns exactly `TRP_CYC`+1 cycles after that grant, and its grant produces a refresh.
- R3: Debt never exceeds `MAX_DEBT`. `arb_urgent_o` is high exactly while a request is pending with the debt at the ceiling. After saturation, exactly `MAX_DEBT` refreshes drain it, and urgency drops after the first of them.
- R4: Once raised, `arb_req_o` stays high until `arb_gnt_i` is seen.
- R5: After a refresh is granted in cycle g, `block_all_o` is high in cycles g+1 through g+`TRFC_CYC`-1 and low in cycle g+`TRFC_CYC`.
- R6: `cke_o` is high in every cycle of a refresh, from its grant until `TRFC_CYC` has passed.
- R7: A grant that lands on the same edge as an interval tick leaves the debt unchanged, so a second refresh is requested afterwards.
- R8: With `sr_enter_i`, the scheduler precharges if needed, then requests self-refresh entry. `cke_o` is low from the next cycle. No request is made while in self refresh, `sr_enter_i` is ignored there, and all debt is discarded.
- R9: `sr_exit_i` during self refresh yields the exit command in that same cycle x. `block_all_o` is then high through cycle x+`TXSNR_CYC`-1, and `block_read_o` is high through cycle x+`TXSRD_CYC`-1.
- R10: The interval restarts at self-refresh exit. The next request appears in cycle x+`REFI_CYC`+2.
- R11: `cmd_o` codes: 0 idle, 1 precharge-all, 2 refresh, 3 self-refresh entry, 4 self-refresh exit. A non-idle code appears only in the cycle of a grant, or in the cycle of an exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| banks_open_i | input | 1 | Some bank currently has an open row |
| sr_enter_i | input | 1 | Ask to enter self refresh |
| sr_exit_i | input | 1 | Ask to leave self refresh |
| arb_gnt_i | input | 1 | Arbiter grants the pending request this cycle |
| arb_req_o | output | 1 | Scheduler wants a command slot |
| arb_urgent_o | output | 1 | Pending request must pre-empt other traffic |
| cmd_o | output | 3 | Command issued this cycle (R11 codes) |
| cke_o | output | 1 | Clock enable to the memory |
| block_all_o | output | 1 | Arbiter must issue no command |
| block_read_o | output | 1 | Arbiter must issue no read |

## Verification
Two functions can fall on the same clock edge: the interval counter adding a unit of debt, and a refresh grant removing one. The bench tracks the edge count since reset and holds off its grant until the cycle just before an interval boundary, so that both updates hit one edge. It then judges the result at the ports: a correct block asks for exactly one more refresh afterwards and then goes quiet. The bench also drains a saturated debt just after a boundary, so that no tick falls inside the drain, and counts exactly the ceiling.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_PREA = 3'd1,
        CMD_REF  = 3'd2,
        CMD_SRE  = 3'd3,
        CMD_SRX  = 3'd4
    } rfsh_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE_REQ,
        ST_PRE_WAIT,
        ST_REF_REQ,
        ST_REF_WAIT,
        ST_SRE_REQ,
        ST_SELF
    } rfsh_state_e;

    typedef struct packed {
        rfsh_state_e st;
        logic        tgt_sr;
    } rfsh_ctl_t;

endpackage

// File: rtl/rfsh_interval.sv
module rfsh_interval #(
    parameter int REFI_CYC = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic tick_o
);
    localparam int CW = (REFI_CYC > 1) ? $clog2(REFI_CYC) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(REFI_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (restart_i || cnt_q == '0) begin
            cnt_d = RELOAD;
        end else begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= RELOAD;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign tick_o = !restart_i && (cnt_q == '0);

endmodule

// File: rtl/rfsh_debt.sv
module rfsh_debt #(
    parameter int MAX_DEBT = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tick_i,
    input  logic                          dec_i,
    input  logic                          clr_i,
    output logic [$clog2(MAX_DEBT+1)-1:0] debt_o,
    output logic                          full_o
);
    localparam int DW = $clog2(MAX_DEBT + 1);
    localparam logic [DW-1:0] CEIL = DW'(MAX_DEBT);

    logic [DW-1:0] debt_d, debt_q;

    always_comb begin
        debt_d = debt_q;
        if (clr_i) begin
            debt_d = '0;
        end else begin
            case ({tick_i, dec_i})
                2'b10: if (debt_q != CEIL) debt_d = debt_q + 1'b1;
                2'b01: if (debt_q != '0)   debt_d = debt_q - 1'b1;
                default: debt_d = debt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            debt_q <= '0;
        end else begin
            debt_q <= debt_d;
        end
    end

    assign debt_o = debt_q;
    assign full_o = (debt_q == CEIL);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && tick_i && !dec_i && !clr_i) |=> full_o); // R3

    AST_TICK_GRANT_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && dec_i && !clr_i) |=> (debt_o == $past(debt_o))); // R7

endmodule

// File: rtl/rfsh_down_ctr.sv
module rfsh_down_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         busy_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load_i) begin
            cnt_d = val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end else begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched
    import rfsh_pkg::*;
#(
    parameter int REFI_CYC  = 1560,
    parameter int MAX_DEBT  = 8,
    parameter int TRFC_CYC  = 15,
    parameter int TRP_CYC   = 4,
    parameter int TXSNR_CYC = 15,
    parameter int TXSRD_CYC = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       banks_open_i,
    input  logic       sr_enter_i,
    input  logic       sr_exit_i,
    input  logic       arb_gnt_i,
    output logic       arb_req_o,
    output logic       arb_urgent_o,
    output logic [2:0] cmd_o,
    output logic       cke_o,
    output logic       block_all_o,
    output logic       block_read_o
);
    localparam int WAIT_MAX = (TRFC_CYC > TRP_CYC) ? TRFC_CYC : TRP_CYC;
    localparam int WW  = $clog2(WAIT_MAX + 1);
    localparam int XNW = $clog2(TXSNR_CYC + 1);
    localparam int XRW = $clog2(TXSRD_CYC + 1);
    localparam int DW  = $clog2(MAX_DEBT + 1);

    rfsh_ctl_t     ctl_d, ctl_q;
    logic          tick, debt_full, in_self, ref_issue;
    logic [DW-1:0] debt;
    logic          wait_load, wait_busy, xs_load, xsnr_busy, xsrd_busy;
    logic [WW-1:0] wait_val;
    rfsh_cmd_e     cmd_e;

    assign in_self   = (ctl_q.st == ST_SELF);
    assign arb_req_o = (ctl_q.st == ST_PRE_REQ) || (ctl_q.st == ST_REF_REQ) ||
                       (ctl_q.st == ST_SRE_REQ);
    assign ref_issue = (ctl_q.st == ST_REF_REQ) && arb_gnt_i;

    rfsh_interval #(.REFI_CYC(REFI_CYC)) u_interval (
        .clk(clk), .rst_n(rst_n), .restart_i(in_self), .tick_o(tick)
    );

    rfsh_debt #(.MAX_DEBT(MAX_DEBT)) u_debt (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .dec_i(ref_issue),
        .clr_i(in_self), .debt_o(debt), .full_o(debt_full)
    );

    rfsh_down_ctr #(.W(WW)) u_wait (
        .clk(clk), .rst_n(rst_n), .load_i(wait_load), .val_i(wait_val),
        .busy_o(wait_busy)
    );

    rfsh_down_ctr #(.W(XNW)) u_xsnr (
        .clk(clk), .rst_n(rst_n), .load_i(xs_load),
        .val_i(XNW'(TXSNR_CYC - 1)), .busy_o(xsnr_busy)
    );

    rfsh_down_ctr #(.W(XRW)) u_xsrd (
        .clk(clk), .rst_n(rst_n), .load_i(xs_load),
        .val_i(XRW'(TXSRD_CYC - 1)), .busy_o(xsrd_busy)
    );

    always_comb begin
        ctl_d     = ctl_q;
        wait_load = 1'b0;
        wait_val  = '0;
        xs_load   = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (!xsnr_busy) begin
                    if (sr_enter_i) begin
                        ctl_d.tgt_sr = 1'b1;
                        ctl_d.st     = banks_open_i ? ST_PRE_REQ : ST_SRE_REQ;
                    end else if (debt != '0) begin
                        ctl_d.tgt_sr = 1'b0;
                        ctl_d.st     = banks_open_i ? ST_PRE_REQ : ST_REF_REQ;
                    end
                end
            end
            ST_PRE_REQ: begin
                if (arb_gnt_i) begin
                    ctl_d.st  = ST_PRE_WAIT;
                    wait_load = 1'b1;
                    wait_val  = WW'(TRP_CYC - 1);
                end
            end
            ST_PRE_WAIT: begin
                if (!wait_busy) begin
                    ctl_d.st = ctl_q.tgt_sr ? ST_SRE_REQ : ST_REF_REQ;
                end
            end
            ST_REF_REQ: begin
                if (arb_gnt_i) begin
                    ctl_d.st  = ST_REF_WAIT;
                    wait_load = 1'b1;
                    wait_val  = WW'(TRFC_CYC - 1);
                end
            end
            ST_REF_WAIT: begin
                if (!wait_busy) begin
                    ctl_d.st = ST_IDLE;
                end
            end
            ST_SRE_REQ: begin
                if (arb_gnt_i) begin
                    ctl_d.st = ST_SELF;
                end
            end
            ST_SELF: begin
                if (sr_exit_i) begin
                    ctl_d.st = ST_IDLE;
                    xs_load  = 1'b1;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, tgt_sr: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        cmd_e = CMD_NOP;
        if (arb_req_o && arb_gnt_i) begin
            case (ctl_q.st)
                ST_PRE_REQ: cmd_e = CMD_PREA;
                ST_REF_REQ: cmd_e = CMD_REF;
                default:    cmd_e = CMD_SRE;
            endcase
        end else if (in_self && sr_exit_i) begin
            cmd_e = CMD_SRX;
        end
    end

    assign cmd_o        = cmd_e;
    assign cke_o        = !in_self;
    assign arb_urgent_o = arb_req_o && debt_full;
    assign block_all_o  = wait_busy || xsnr_busy || in_self;
    assign block_read_o = block_all_o || xsrd_busy;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_req_o && !arb_gnt_i) |=> arb_req_o); // R4

    AST_RFC_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_REF) |=> (block_all_o && cke_o)); // R5

    AST_SR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cke_o |-> (!arb_req_o && (cmd_o == CMD_NOP || cmd_o == CMD_SRX))); // R8

    AST_XS_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_SRX) |=> (block_all_o && block_read_o && cke_o)); // R9

endmodule

// File: tb/tb_rfsh_sched.sv
`timescale 1ns/1ps
module tb_rfsh_sched;
    localparam int REFI  = 100;
    localparam int MAXD  = 8;
    localparam int TRFC  = 6;
    localparam int TRP   = 3;
    localparam int TXSNR = 5;
    localparam int TXSRD = 20;

    localparam logic [2:0] C_NOP = 3'd0, C_PREA = 3'd1, C_REF = 3'd2,
                           C_SRE = 3'd3, C_SRX = 3'd4;

    typedef struct packed {
        logic       bo;
        logic [2:0] exp;
    } vec_t;
    localparam vec_t VECS [4] = '{
        '{bo: 1'b0, exp: 3'd2},
        '{bo: 1'b1, exp: 3'd1},
        '{bo: 1'b1, exp: 3'd1},
        '{bo: 1'b0, exp: 3'd2}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic banks_open = 1'b0, sr_enter = 1'b0, sr_exit = 1'b0, gnt = 1'b0;
    logic req, urgent, cke, block_all, block_read;
    logic [2:0] cmd;

    int cyc = 0, checks = 0, failures = 0;
    bit done = 1'b0;

    rfsh_sched #(.REFI_CYC(REFI), .MAX_DEBT(MAXD), .TRFC_CYC(TRFC),
                 .TRP_CYC(TRP), .TXSNR_CYC(TXSNR), .TXSRD_CYC(TXSRD)) dut (
        .clk(clk), .rst_n(rst_n), .banks_open_i(banks_open),
        .sr_enter_i(sr_enter), .sr_exit_i(sr_exit), .arb_gnt_i(gnt),
        .arb_req_o(req), .arb_urgent_o(urgent), .cmd_o(cmd), .cke_o(cke),
        .block_all_o(block_all), .block_read_o(block_read)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (cyc %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic to_cyc(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic grant_one(output int g, output logic [2:0] c);
        gnt = 1'b1;
        #1;
        c = cmd;
        g = cyc;
        @(negedge clk);
        gnt = 1'b0;
        #0.1;
    endtask

    task automatic wait_req(input int lim, output bit ok);
        ok = 1'b0;
        for (int i = 0; i <= lim; i++) begin
            if (req) begin
                ok = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int g, g2, x, n, bad;
        bit ok;
        logic [2:0] c;

        step(4);
        rst_n = 1'b1;

        // Reset state
        chk(req == 1'b0, "R1 reset req", req, 0);
        chk(cke == 1'b1, "R6 reset cke", cke, 1);
        chk(block_all == 1'b0, "R5 reset block_all", block_all, 0);
        chk(block_read == 1'b0, "R9 reset block_read", block_read, 0);
        chk(cmd == C_NOP, "R11 reset cmd", cmd, C_NOP);

        // First request timing and refresh window
        to_cyc(REFI);
        chk(req == 1'b0, "R1 req before interval", req, 0);
        step(1);
        chk(req == 1'b1, "R1 req after interval", req, 1);
        chk(urgent == 1'b0, "R3 no urgency at one owed", urgent, 0);
        grant_one(g, c);
        chk(c == C_REF, "R11 refresh code", c, C_REF);
        bad = 0;
        for (int k = 1; k < TRFC; k++) begin
            if (!block_all || !cke) bad++;
            step(1);
        end
        chk(bad == 0, "R5 R6 blocked with cke high during tRFC", bad, 0);
        chk(block_all == 1'b0, "R5 released at tRFC", block_all, 0);
        chk(req == 1'b0, "R1 debt paid", req, 0);

        // Table of refresh attempts with and without open banks
        foreach (VECS[i]) begin
            banks_open = VECS[i].bo;
            wait_req(2 * REFI, ok);
            chk(ok, "R1 periodic request", ok, 1);
            grant_one(g, c);
            chk(c == VECS[i].exp, "R2 first command", c, VECS[i].exp);
            if (VECS[i].exp == C_PREA) begin
                banks_open = 1'b0;
                chk(block_all == 1'b1, "R2 blocked during tRP", block_all, 1);
                to_cyc(g + TRP);
                chk(req == 1'b0, "R2 no refresh before tRP", req, 0);
                step(1);
                chk(req == 1'b1, "R2 refresh after tRP", req, 1);
                grant_one(g, c);
                chk(c == C_REF, "R2 refresh after precharge", c, C_REF);
            end
            to_cyc(g + TRFC + 2);
        end

        // Saturation, hold and drain
        wait_req(2 * REFI, ok);
        bad = 0;
        for (int i = 0; i < 10 * REFI; i++) begin
            if (!req) bad++;
            step(1);
        end
        chk(bad == 0, "R4 request held without grant", bad, 0);
        chk(urgent == 1'b1, "R3 urgent at ceiling", urgent, 1);
        while (cyc % REFI != 1) step(1);
        n = 0;
        do begin
            grant_one(g, c);
            n++;
            chk(c == C_REF, "R3 drain refresh code", c, C_REF);
            to_cyc(g + TRFC + 2);
            if (n == 1) chk(urgent == 1'b0, "R3 urgency drops below ceiling", urgent, 0);
        end while (req && n < 20);
        chk(n == MAXD, "R3 drained count equals ceiling", n, MAXD);

        // Tick and grant on the same edge
        x = (cyc / REFI + 2) * REFI;
        to_cyc(x - 1);
        chk(req == 1'b1, "R7 request pending", req, 1);
        grant_one(g, c);
        to_cyc(g + TRFC + 2);
        chk(req == 1'b1, "R7 coincident tick kept", req, 1);
        grant_one(g2, c);
        to_cyc(g2 + TRFC + 2);
        chk(req == 1'b0, "R7 debt paid after second", req, 0);

        // Self refresh entry with open banks
        banks_open = 1'b1;
        sr_enter = 1'b1;
        wait_req(4, ok);
        sr_enter = 1'b0;
        chk(ok, "R8 entry request", ok, 1);
        grant_one(g, c);
        chk(c == C_PREA, "R8 precharge before entry", c, C_PREA);
        banks_open = 1'b0;
        to_cyc(g + TRP + 1);
        chk(req == 1'b1, "R8 entry request after tRP", req, 1);
        grant_one(g, c);
        chk(c == C_SRE, "R8 entry code", c, C_SRE);
        chk(cke == 1'b0, "R8 cke low", cke, 0);
        chk(block_all == 1'b1, "R8 blocked in self refresh", block_all, 1);
        bad = 0;
        for (int i = 0; i < 3 * REFI; i++) begin
            sr_enter = (i == REFI);
            if (req || cke || cmd != C_NOP) bad++;
            step(1);
        end
        sr_enter = 1'b0;
        chk(bad == 0, "R8 quiet in self refresh", bad, 0);

        // Self refresh exit
        sr_exit = 1'b1;
        #1;
        chk(cmd == C_SRX, "R9 exit code", cmd, C_SRX);
        x = cyc;
        @(negedge clk);
        sr_exit = 1'b0;
        chk(cke == 1'b1, "R9 cke restored", cke, 1);
        chk(block_all && block_read, "R9 both blocked after exit", block_all, 1);
        to_cyc(x + TXSNR - 1);
        chk(block_all == 1'b1, "R9 non-read blocked until tXSNR", block_all, 1);
        to_cyc(x + TXSNR);
        chk(block_all == 1'b0, "R9 non-read released", block_all, 0);
        chk(block_read == 1'b1, "R9 read still blocked", block_read, 1);
        to_cyc(x + TXSRD - 1);
        chk(block_read == 1'b1, "R9 read blocked until tXSRD", block_read, 1);
        to_cyc(x + TXSRD);
        chk(block_read == 1'b0, "R9 read released", block_read, 0);
        to_cyc(x + REFI + 1);
        chk(req == 1'b0, "R10 no request before restarted interval", req, 0);
        step(1);
        chk(req == 1'b1, "R10 request after restarted interval", req, 1);
        grant_one(g, c);
        to_cyc(g + TRFC + 2);
        chk(req == 1'b0, "R8 debt discarded in self refresh", req, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule